// File: doc/BRIEF.md
# Interrupt Line Source Selector

This block sits between the general-purpose I/O ports and the external interrupt controller. Each of the 16 interrupt lines is tied to one pin position. Line n can only carry pin n of some port, and a 4-bit selector per line chooses which port that is. The selector fields come from the configuration register file as one 64-bit vector. That vector is viewed as four 16-bit select registers, and each register holds the fields for four consecutive lines. The pin levels of all ports arrive flattened, with port p, pin k at bit p*16 + k.

Eight ports are present. A selector value that names no port (8 to 15) ties its line low. The line levels are registered, so the downstream edge logic sees clean levels one clock after the chosen pin. Edge detection, masking and pending state belong to the interrupt controller and are not part of this block.

Top module: `exti_src_sel`

## Requirements
- R1: While rst_n is low, line_out is all zeros whatever the inputs, and it stays zero until the first rising clock edge with rst_n high.
- R2: Line n takes its selector from sel_cfg bits [16*(n/4) + 4*(n%4) + 3 : 16*(n/4) + 4*(n%4)]. This is select register n/4 at bit offset 4*(n mod 4), which is bits [4n+3:4n].
- R3: When line n's selector holds a value v below 8, line n carries pin_lvl[v*16 + n].
- R4: pin_lvl bit p*16 + k never affects any line other than line k.
- R5: A selector of 0 routes port 0 to the line, so an all-zero sel_cfg makes line n follow pin_lvl[n].
- R6: A selector value from 8 to 15 drives its line to 0.
- R7: Each line is registered. A change on a selected pin shows on line_out after the next rising clock edge and not before.
- R8: If a selector and the pins change in the same cycle, the line shows the newly selected port's pin value of that cycle after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_cfg | input | 64 | Packed port selectors, four 16-bit select registers |
| pin_lvl | input | 128 | All port pin levels, bit port*16 + pin |
| line_out | output | 16 | Registered interrupt line levels |

## Verification
A selector rewrite and a pin change can arrive on the same clock. The line must then take the new port's value from that same cycle, not the old port's value and not a stale pin. The bench provokes this with a phase that redraws every selector and every pin level on each cycle. A behavioural model computes each line from the values presented before the edge and judges the result one clock later. Separate phases push invalid selectors and single-pin patterns across the same path, which exposes routing that leaks between pin positions.

// File: rtl/exti_sel_pkg.sv
package exti_sel_pkg;

  // Number of selector fields held in one select register.
  localparam int FIELDS_PER_REG = 4;

  // Bit offset of a line's field inside its select register.
  function automatic int field_offset(int line, int sel_w);
    return (line % FIELDS_PER_REG) * sel_w;
  endfunction

  // Select register that holds a line's field.
  function automatic int field_reg(int line);
    return line / FIELDS_PER_REG;
  endfunction

  // Flattened position of a port pin in the pin level vector.
  function automatic int pin_index(int port, int pin, int pins_per_port);
    return port * pins_per_port + pin;
  endfunction

  // Width of a port index; never below one bit.
  function automatic int port_width(int nports);
    return (nports > 1) ? $clog2(nports) : 1;
  endfunction

endpackage

// File: rtl/exti_sel_unpack.sv
module exti_sel_unpack #(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_LINES*SEL_W-1:0]            sel_cfg,
  output logic [NUM_LINES-1:0][SEL_W-1:0]       sel_line
);
  localparam int REG_W    = exti_sel_pkg::FIELDS_PER_REG * SEL_W;
  localparam int NUM_REGS = (NUM_LINES + exti_sel_pkg::FIELDS_PER_REG - 1)
                            / exti_sel_pkg::FIELDS_PER_REG;

  // Register view of the flat selector vector.
  logic [NUM_REGS-1:0][REG_W-1:0] sel_regs;

  generate
    if (NUM_REGS * REG_W == NUM_LINES * SEL_W) begin : g_exact
      assign sel_regs = sel_cfg;
    end else begin : g_pad
      assign sel_regs = {{(NUM_REGS*REG_W - NUM_LINES*SEL_W){1'b0}}, sel_cfg};
    end
  endgenerate

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_line
      localparam int REG_IX = exti_sel_pkg::field_reg(n);
      localparam int OFFSET = exti_sel_pkg::field_offset(n, SEL_W);
      assign sel_line[n] = sel_regs[REG_IX][OFFSET +: SEL_W];
    end
  endgenerate
endmodule

// File: rtl/exti_line_mux.sv
module exti_line_mux #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int LINE_IDX  = 0,
  parameter int COL_W     = 8
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0] pin_lvl,
  input  logic [SEL_W-1:0]               sel,
  output logic [COL_W-1:0]               column,
  output logic [COL_W-1:0]               port_hit,
  output logic                           sel_valid,
  output logic                           line_d
);
  // Column of candidate pins: pin LINE_IDX of every port.
  genvar p;
  generate
    for (p = 0; p < COL_W; p++) begin : g_col
      if (p < NUM_PORTS) begin : g_real
        localparam int IDX = exti_sel_pkg::pin_index(p, LINE_IDX, NUM_LINES);
        assign column[p]   = pin_lvl[IDX];
        assign port_hit[p] = (32'(sel) == p);
      end else begin : g_none
        assign column[p]   = 1'b0;
        assign port_hit[p] = 1'b0;
      end
    end
  endgenerate

  assign sel_valid = (32'(sel) < NUM_PORTS);
  assign line_d    = |(port_hit & column);
endmodule

// File: rtl/exti_line_reg.sv
module exti_line_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/exti_src_sel.sv
module exti_src_sel #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES*SEL_W-1:0]     sel_cfg,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pin_lvl,
  output logic [NUM_LINES-1:0]           line_out
);
  localparam int PORT_W = exti_sel_pkg::port_width(NUM_PORTS);
  localparam int COL_W  = 1 << PORT_W;

  logic [NUM_LINES-1:0][SEL_W-1:0] sel_line;
  logic [NUM_LINES-1:0][COL_W-1:0] col_w;
  logic [NUM_LINES-1:0][COL_W-1:0] hit_w;
  logic [NUM_LINES-1:0]            valid_w;
  logic [NUM_LINES-1:0]            line_d;

  exti_sel_unpack #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_unpack (
    .sel_cfg  (sel_cfg),
    .sel_line (sel_line)
  );

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_mux
      exti_line_mux #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_LINES (NUM_LINES),
        .SEL_W     (SEL_W),
        .LINE_IDX  (n),
        .COL_W     (COL_W)
      ) u_mux (
        .pin_lvl   (pin_lvl),
        .sel       (sel_line[n]),
        .column    (col_w[n]),
        .port_hit  (hit_w[n]),
        .sel_valid (valid_w[n]),
        .line_d    (line_d[n])
      );
    end
  endgenerate

  exti_line_reg #(.W(NUM_LINES)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_d),
    .q     (line_out)
  );

  // High once a clock edge has been seen out of reset; gates $past use.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_chk
      p_follow_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(valid_w[n]) |->
          line_out[n] == $past(col_w[n][sel_line[n][PORT_W-1:0]]));

      p_zero_sel_port0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(sel_line[n]) == '0) |-> line_out[n] == $past(pin_lvl[n]));

      p_bad_sel_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(valid_w[n]) |-> !line_out[n]);
    end
  endgenerate

  p_hold_when_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && $past($stable(pin_lvl) && $stable(sel_cfg))
      |-> $stable(line_out));
endmodule

// File: tb/exti_src_sel_test.sv
module exti_src_sel_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  sel_cfg = '0;
  logic [127:0] pin_lvl = '0;
  logic [15:0]  line_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_q = '0;

  always #5 clk = ~clk;

  exti_src_sel uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_cfg  (sel_cfg),
    .pin_lvl  (pin_lvl),
    .line_out (line_out)
  );

  // Behavioural model: line k picks nibble k of the selector vector.
  function automatic logic [15:0] model(logic [63:0] s, logic [127:0] p);
    logic [15:0] r = '0;
    for (int k = 0; k < 16; k++) begin
      int v = int'((s >> (4 * k)) & 64'hF);
      if (v < 8) r[k] = p[v * 16 + k];
    end
    return r;
  endfunction

  task automatic chk(input logic [15:0] want, input string tag);
    total++;
    if (line_out !== want) begin
      bad++;
      $display("FAIL %s: line_out=%h expected=%h", tag, line_out, want);
    end
  endtask

  // Present current inputs to one edge, then compare at the falling edge.
  task automatic tick(input string tag);
    logic [15:0] nxt = rst_n ? model(sel_cfg, pin_lvl) : 16'h0;
    @(posedge clk);
    exp_q = nxt;
    @(negedge clk);
    chk(exp_q, tag);
  endtask

  function automatic logic [127:0] rnd_pins();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [63:0] rnd_valid_sel();
    logic [63:0] s = '0;
    for (int k = 0; k < 16; k++) s[4*k +: 4] = 4'($urandom % 8);
    return s;
  endfunction

  initial begin
    @(negedge clk);
    // R1: reset holds lines low with every pin high.
    pin_lvl = '1;
    for (int i = 0; i < 3; i++) tick("R1");
    rst_n = 1'b1;

    // R5: all-zero selectors route port 0.
    for (int i = 0; i < 4; i++) begin
      pin_lvl = rnd_pins();
      tick("R5");
    end

    // R2: one field at a time selects port 5, all others port 0.
    for (int k = 0; k < 16; k++) begin
      sel_cfg = '0;
      sel_cfg[4*k +: 4] = 4'd5;
      pin_lvl = '0;
      pin_lvl[5*16 +: 16] = 16'hFFFF;
      tick("R2");
    end

    // R4: every line on port 2, a single pin of port 2 high, others ports high.
    sel_cfg = {16{4'd2}};
    for (int k = 0; k < 16; k++) begin
      pin_lvl = '1;
      pin_lvl[2*16 +: 16] = 16'h0;
      pin_lvl[2*16 + k] = 1'b1;
      tick("R4");
    end

    // R6: selectors 8..15 give low lines even with all pins high.
    pin_lvl = '1;
    for (int v = 8; v < 16; v++) begin
      sel_cfg = {16{4'(v)}};
      tick("R6");
    end

    // R7: a pin change is not visible before the edge, and is after it.
    sel_cfg = '0;
    pin_lvl = '0;
    tick("R7");
    for (int i = 0; i < 6; i++) begin
      pin_lvl = rnd_pins();
      #1;
      chk(exp_q, "R7");
      tick("R7");
    end

    // R8: selector and pins both change every cycle.
    for (int i = 0; i < 40; i++) begin
      sel_cfg = rnd_valid_sel();
      pin_lvl = rnd_pins();
      tick("R8");
    end

    // R3: general routing with any selector values.
    for (int i = 0; i < 300; i++) begin
      sel_cfg = {$urandom, $urandom};
      if (i % 3 == 0) sel_cfg = rnd_valid_sel();
      pin_lvl = rnd_pins();
      tick("R3");
    end

    // R1: reset asserted again mid-run clears the lines.
    pin_lvl = '1;
    sel_cfg = '0;
    rst_n = 1'b0;
    #1;
    chk(16'h0, "R1");
    tick("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: line_out=%h expected=finish", line_out);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule